// File: doc/BRIEF.md
# Multiframe Nibble Exchange

This block runs the once-per-multiframe swap of four-bit maintenance nibbles on a framed line. It keeps a frame position of 1 to 20 and a baud position of 1 to 48 inside each frame, both driven by strobes from the line framer. A frame-start strobe that comes with a multiframe sync pulse aligns the counter to frame 1. Each subchannel carries one bit in each of four fixed frames. The block gathers the bits of five receive subchannels into a hidden shadow copy. At one fixed instant, baud 47 of frame 20, it does two things at once: it copies the shadow to the visible receive register, and in terminal mode it takes the transmit Q-channel nibble from the upper half of a host-written buffer register.

A status bit reports each publication to the host. In the per-multiframe setting it is raised on every publication. In the per-nibble setting it is raised only when the published data differ from what was shown before. A host read of the receive register clears the bit. This works the same way in network and terminal modes. There is no write path to the bit. The interrupt line is the status bit gated by a host enable.

Two state machines carry the control. The alignment machine has the states SEEK (no multiframe sync seen yet) and LOCK (counting). Its one transition, SEEK to LOCK, is taken on a frame start that comes with the sync pulse. LOCK has no exit, and a later sync pulse only resets the frame position to 1. The status machine has the states IDLE and PEND. IDLE goes to PEND when a publication raises the status. PEND goes back to IDLE on a host read, unless a publication occurs in the same cycle.

Top module: `mfx_nibble_xchg`

## Requirements
- R1: While reset is asserted and after it is released, tx_q_nibble, rx_nibbles, irq_status, irq and aligned are all 0.
- R2: A frame_start without mf_sync is ignored until the first frame_start with mf_sync, which sets aligned to 1. After that, aligned stays 1. The frame position goes from 20 back to 1, and any frame_start with mf_sync puts it back to 1.
- R3: In terminal mode (te_mode=1), tx_q_nibble takes host_tx_reg[7:4] on the baud_tick that is baud 47 of frame 20. The new value is visible one cycle later. At all other times it holds.
- R4: In network mode (te_mode=0), tx_q_nibble keeps its value at the latch instant as well.
- R5: The bit of subchannel k (k=1..5) is taken from rx_sc_bits[k-1] on the frame_start of frames 1, 6, 11 and 16. These fill nibble bits 3, 2, 1 and 0 in that order. Subchannel k appears at rx_nibbles[4k-1:4k-4].
- R6: rx_nibbles changes only at the latch instant of R3, and it does so in both modes.
- R7: With irq_every_nibble=0, every latch instant sets irq_status.
- R8: With irq_every_nibble=1, a latch instant sets irq_status only when the newly published rx_nibbles differ from the previous value.
- R9: A host_rd_rx pulse clears irq_status one cycle later in either mode. If a setting latch instant falls in the same cycle, the bit stays set.
- R10: While irq_status is pending, a further latch instant keeps it set and overwrites rx_nibbles with the newer data.
- R11: irq is 1 exactly when irq_status is 1 and irq_en is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| te_mode | input | 1 | 1 = terminal mode (transmit latch active), 0 = network mode |
| irq_every_nibble | input | 1 | 1 = raise status only on changed data, 0 = every multiframe |
| irq_en | input | 1 | Interrupt enable |
| frame_start | input | 1 | First baud of a frame; always comes with baud_tick |
| mf_sync | input | 1 | With frame_start: this frame is frame 1 |
| baud_tick | input | 1 | One pulse per baud |
| rx_sc_bits | input | 5 | Current received bit of each subchannel |
| host_tx_reg | input | 8 | Host transmit buffer; upper nibble is the Q nibble |
| host_rd_rx | input | 1 | Host read strobe of the receive register |
| aligned | output | 1 | Multiframe alignment held |
| tx_q_nibble | output | 4 | Latched Q-channel nibble to transmit |
| rx_nibbles | output | 20 | Published subchannel nibbles SC1..SC5 |
| irq_status | output | 1 | Multiframe status bit, read-only |
| irq | output | 1 | Gated interrupt request |

## Verification
The assertions take for granted that frame_start always comes with a baud_tick and that each frame carries exactly 48 baud ticks. If either fails, the latch instant has no meaning. They also assume that the host strobes are synchronous single-cycle pulses. The stimulus produces every frame from one task that emits 48 ticks, each two clocks apart, with the frame strobe on the first tick. Host reads are placed at chosen frame and baud positions of that same task. One of them falls on the latch tick itself, to exercise the case where a set and a clear arrive together.

// File: rtl/mfx_pkg.sv
package mfx_pkg;
    typedef enum logic [0:0] {TRK_SEEK, TRK_LOCK} trk_state_t;
    typedef enum logic [0:0] {IRQ_IDLE, IRQ_PEND} irq_state_t;
endpackage

// File: rtl/mfx_frame_track.sv
module mfx_frame_track
    import mfx_pkg::*;
#(
    parameter int FRAMES      = 20,
    parameter int BAUDS       = 48,
    parameter int LATCH_FRAME = 20,
    parameter int LATCH_BAUD  = 47,
    localparam int FW = $clog2(FRAMES + 1),
    localparam int BW = $clog2(BAUDS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_start,
    input  logic          mf_sync,
    input  logic          baud_tick,
    output logic          aligned,
    output logic          fr_go,
    output logic [FW-1:0] fr_next,
    output logic          latch_ev
);
    trk_state_t    st_q, st_d;
    logic [FW-1:0] frame_q;
    logic [BW-1:0] baud_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= TRK_SEEK;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            TRK_SEEK: if (frame_start && mf_sync) st_d = TRK_LOCK;
            TRK_LOCK: st_d = TRK_LOCK;
        endcase
    end

    // outputs
    always_comb begin
        aligned = (st_q == TRK_LOCK);
        fr_go   = frame_start && (mf_sync || st_q == TRK_LOCK);
        if (mf_sync || frame_q == FW'(FRAMES)) fr_next = FW'(1);
        else                                    fr_next = frame_q + FW'(1);
        latch_ev = (st_q == TRK_LOCK) && baud_tick && !frame_start &&
                   (baud_q == BW'(LATCH_BAUD - 1)) && (frame_q == FW'(LATCH_FRAME));
    end

    // position counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_q <= '0;
            baud_q  <= '0;
        end else if (fr_go) begin
            frame_q <= fr_next;
            baud_q  <= BW'(1);
        end else if (st_q == TRK_LOCK && baud_tick && baud_q != BW'(BAUDS)) begin
            baud_q <= baud_q + BW'(1);
        end
    end
endmodule

// File: rtl/mfx_rx_collect.sv
module mfx_rx_collect #(
    parameter int FRAMES = 20,
    parameter int NSUB   = 5,
    parameter int NIB    = 4,
    localparam int FW      = $clog2(FRAMES + 1),
    localparam int SPACING = FRAMES / NIB,
    localparam int TOT     = NSUB * NIB
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fr_go,
    input  logic [FW-1:0]   fr_next,
    input  logic [NSUB-1:0] rx_sc_bits,
    input  logic            publish,
    output logic [TOT-1:0]  pub_q,
    output logic            changed
);
    logic [TOT-1:0] shadow_q;

    for (genvar s = 0; s < NSUB; s++) begin : g_sub
        for (genvar j = 0; j < NIB; j++) begin : g_bit
            localparam int FN  = 1 + j * SPACING;
            localparam int POS = s * NIB + (NIB - 1 - j);
            always_ff @(posedge clk) begin
                if (!rst_n)                           shadow_q[POS] <= 1'b0;
                else if (fr_go && fr_next == FW'(FN)) shadow_q[POS] <= rx_sc_bits[s];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       pub_q <= '0;
        else if (publish) pub_q <= shadow_q;
    end

    assign changed = (shadow_q != pub_q);
endmodule

// File: rtl/mfx_irq_ctl.sv
module mfx_irq_ctl
    import mfx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    input  logic clr_req,
    output logic status
);
    irq_state_t st_q, st_d;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= IRQ_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            IRQ_IDLE: if (set_req)             st_d = IRQ_PEND;
            IRQ_PEND: if (clr_req && !set_req) st_d = IRQ_IDLE;
        endcase
    end

    always_comb status = (st_q == IRQ_PEND);
endmodule

// File: rtl/mfx_nibble_xchg.sv
module mfx_nibble_xchg #(
    parameter int FRAMES      = 20,
    parameter int BAUDS       = 48,
    parameter int LATCH_FRAME = 20,
    parameter int LATCH_BAUD  = 47,
    parameter int NSUB        = 5,
    parameter int NIB         = 4,
    parameter int REG_W       = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                te_mode,
    input  logic                irq_every_nibble,
    input  logic                irq_en,
    input  logic                frame_start,
    input  logic                mf_sync,
    input  logic                baud_tick,
    input  logic [NSUB-1:0]     rx_sc_bits,
    input  logic [REG_W-1:0]    host_tx_reg,
    input  logic                host_rd_rx,
    output logic                aligned,
    output logic [NIB-1:0]      tx_q_nibble,
    output logic [NSUB*NIB-1:0] rx_nibbles,
    output logic                irq_status,
    output logic                irq
);
    localparam int FW = $clog2(FRAMES + 1);

    logic          fr_go;
    logic [FW-1:0] fr_next;
    logic          latch_ev;
    logic          changed;
    logic          set_req;
    logic          unused_low;

    mfx_frame_track #(
        .FRAMES(FRAMES), .BAUDS(BAUDS),
        .LATCH_FRAME(LATCH_FRAME), .LATCH_BAUD(LATCH_BAUD)
    ) u_trk (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .mf_sync(mf_sync),
        .baud_tick(baud_tick), .aligned(aligned), .fr_go(fr_go),
        .fr_next(fr_next), .latch_ev(latch_ev)
    );

    mfx_rx_collect #(.FRAMES(FRAMES), .NSUB(NSUB), .NIB(NIB)) u_rx (
        .clk(clk), .rst_n(rst_n), .fr_go(fr_go), .fr_next(fr_next),
        .rx_sc_bits(rx_sc_bits), .publish(latch_ev), .pub_q(rx_nibbles),
        .changed(changed)
    );

    assign set_req = latch_ev && (!irq_every_nibble || changed);

    mfx_irq_ctl u_irq (
        .clk(clk), .rst_n(rst_n), .set_req(set_req), .clr_req(host_rd_rx),
        .status(irq_status)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)                  tx_q_nibble <= '0;
        else if (latch_ev && te_mode) tx_q_nibble <= host_tx_reg[REG_W-1:REG_W-NIB];
    end

    assign unused_low = ^host_tx_reg[REG_W-NIB-1:0];
    assign irq = irq_status && irq_en;
endmodule

// File: rtl/mfx_nibble_xchg_chk.sv
module mfx_nibble_xchg_chk #(
    parameter int NSUB = 5,
    parameter int NIB  = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                te_mode,
    input logic                irq_every_nibble,
    input logic                irq_en,
    input logic                host_rd_rx,
    input logic                latch_ev,
    input logic                aligned,
    input logic [NIB-1:0]      tx_q_nibble,
    input logic [NSUB*NIB-1:0] rx_nibbles,
    input logic                irq_status,
    input logic                irq
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (!irq_status && tx_q_nibble == '0 && rx_nibbles == '0 && !aligned));

    assert_lock_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        aligned |=> aligned);

    assert_tx_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !latch_ev |=> $stable(tx_q_nibble));

    assert_nt_no_latch_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_ev && !te_mode) |=> $stable(tx_q_nibble));

    assert_rx_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !latch_ev |=> $stable(rx_nibbles));

    assert_mf_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_ev && !irq_every_nibble) |=> irq_status);

    assert_read_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd_rx && !latch_ev) |=> !irq_status);

    assert_pending_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_status && !host_rd_rx) |=> irq_status);

    assert_irq_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (irq_en && irq_status));
endmodule

bind mfx_nibble_xchg mfx_nibble_xchg_chk #(.NSUB(NSUB), .NIB(NIB)) u_chk (
    .clk(clk), .rst_n(rst_n), .te_mode(te_mode), .irq_every_nibble(irq_every_nibble),
    .irq_en(irq_en), .host_rd_rx(host_rd_rx), .latch_ev(latch_ev), .aligned(aligned),
    .tx_q_nibble(tx_q_nibble), .rx_nibbles(rx_nibbles), .irq_status(irq_status),
    .irq(irq)
);

// File: tb/mfx_nibble_xchg_test.sv
`timescale 1ns/1ps
module mfx_nibble_xchg_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        te_mode = 1'b1, irq_every_nibble = 1'b0, irq_en = 1'b1;
    logic        frame_start = 1'b0, mf_sync = 1'b0, baud_tick = 1'b0;
    logic [4:0]  rx_sc_bits = '0;
    logic [7:0]  host_tx_reg = '0;
    logic        host_rd_rx = 1'b0;
    logic        aligned, irq_status, irq;
    logic [3:0]  tx_q_nibble;
    logic [19:0] rx_nibbles;

    int checks = 0, errors = 0;
    int rd_f = 0, rd_b = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    mfx_nibble_xchg uut (
        .clk(clk), .rst_n(rst_n), .te_mode(te_mode), .irq_every_nibble(irq_every_nibble),
        .irq_en(irq_en), .frame_start(frame_start), .mf_sync(mf_sync),
        .baud_tick(baud_tick), .rx_sc_bits(rx_sc_bits), .host_tx_reg(host_tx_reg),
        .host_rd_rx(host_rd_rx), .aligned(aligned), .tx_q_nibble(tx_q_nibble),
        .rx_nibbles(rx_nibbles), .irq_status(irq_status), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // behavioural reference model
    bit          m_trk;
    int          m_frame, m_baud;
    logic [3:0]  m_tx;
    logic [19:0] m_sh, m_pub;
    bit          m_st;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_trk = 0; m_frame = 0; m_baud = 0; m_tx = '0; m_sh = '0; m_pub = '0; m_st = 0;
        end else begin
            bit go, ev, chg, set;
            int nf;
            go = frame_start && (mf_sync || m_trk);
            nf = (mf_sync || m_frame == 20) ? 1 : m_frame + 1;
            ev = m_trk && baud_tick && !frame_start && m_baud == 46 && m_frame == 20;
            chg = 0;
            if (go && (nf - 1) % 5 == 0)
                for (int s = 0; s < 5; s++) m_sh[s*4 + 3 - (nf - 1) / 5] = rx_sc_bits[s];
            if (ev) begin
                chg = (m_sh != m_pub);
                if (te_mode) m_tx = host_tx_reg[7:4];
                m_pub = m_sh;
            end
            set = ev && (!irq_every_nibble || chg);
            if (set) m_st = 1;
            else if (host_rd_rx) m_st = 0;
            if (go) begin m_trk = 1; m_frame = nf; m_baud = 1; end
            else if (m_trk && baud_tick && m_baud < 48) m_baud++;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R2 aligned", aligned, m_trk);
            chk(te_mode ? "R3 tx_q_nibble" : "R4 tx_q_nibble", tx_q_nibble, m_tx);
            chk("R6 rx_nibbles", rx_nibbles, m_pub);
            chk("R9 irq_status", irq_status, m_st);
            chk("R11 irq", irq, m_st && irq_en);
        end
    end

    task automatic send_frame(input bit sync, input logic [4:0] bits, input int f);
        for (int b = 1; b <= 48; b++) begin
            @(negedge clk);
            frame_start = (b == 1);
            mf_sync     = sync && (b == 1);
            baud_tick   = 1'b1;
            rx_sc_bits  = bits;
            host_rd_rx  = (f == rd_f && b == rd_b);
            @(negedge clk);
            frame_start = 1'b0; mf_sync = 1'b0; baud_tick = 1'b0; host_rd_rx = 1'b0;
        end
    endtask

    task automatic send_mf(input bit sync, input logic [19:0] pat);
        for (int f = 1; f <= 20; f++) begin
            logic [4:0] bits;
            bits = 5'($urandom);
            if ((f - 1) % 5 == 0)
                for (int s = 0; s < 5; s++) bits[s] = pat[s*4 + 3 - (f - 1) / 5];
            send_frame(sync && f == 1, bits, f);
        end
    endtask

    task automatic pulse_read();
        @(negedge clk); host_rd_rx = 1'b1;
        @(negedge clk); host_rd_rx = 1'b0;
    endtask

    task automatic finish_up();
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        repeat (4) @(negedge clk);
        chk("R1 reset tx", tx_q_nibble, 0);
        chk("R1 reset rx", rx_nibbles, 0);
        chk("R1 reset status", irq_status, 0);
        chk("R1 reset aligned", aligned, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release irq", irq, 0);

        // unaligned frames are ignored
        host_tx_reg = 8'h9E;
        for (int f = 1; f <= 21; f++) send_frame(0, 5'h1F, f);
        chk("R2 no lock without sync", aligned, 0);
        chk("R2 no latch without sync", tx_q_nibble, 0);

        // first multiframe: per-multiframe mode, terminal
        host_tx_reg = 8'hA5;
        send_mf(1, 20'h3C5A1);
        chk("R2 locked", aligned, 1);
        chk("R3 tx latched", tx_q_nibble, 4'hA);
        chk("R5 rx published", rx_nibbles, 20'h3C5A1);
        chk("R7 status set", irq_status, 1);
        chk("R11 irq out", irq, 1);

        // wraps 20 -> 1 without sync; early read; same data still sets (R7)
        host_tx_reg = 8'h3C; rd_f = 3; rd_b = 10;
        send_mf(0, 20'h3C5A1);
        chk("R2 wrap latch", tx_q_nibble, 4'h3);
        chk("R7 set on unchanged data", irq_status, 1);

        // per-nibble mode: unchanged data does not set
        irq_every_nibble = 1'b1; rd_f = 2; rd_b = 5;
        send_mf(0, 20'h3C5A1);
        chk("R8 no set on unchanged", irq_status, 0);

        // per-nibble mode: changed data sets
        rd_f = 0;
        send_mf(0, 20'hF0E17);
        chk("R8 set on changed", irq_status, 1);
        chk("R5 rx second pattern", rx_nibbles, 20'hF0E17);

        // pending: new latch overwrites data, status stays
        send_mf(0, 20'h6B2D4);
        chk("R10 still pending", irq_status, 1);
        chk("R10 data overwritten", rx_nibbles, 20'h6B2D4);
        pulse_read();
        chk("R9 read clears TE", irq_status, 0);

        // network mode: no tx latch, read on latch tick loses to set
        te_mode = 1'b0; host_tx_reg = 8'hF0; rd_f = 20; rd_b = 47;
        send_mf(0, 20'h81357);
        chk("R4 tx held in NT", tx_q_nibble, 4'h6 ^ 4'h6 ^ 4'h3);
        chk("R6 rx published in NT", rx_nibbles, 20'h81357);
        chk("R9 set wins over read", irq_status, 1);
        irq_en = 1'b0;
        @(negedge clk);
        chk("R11 gated off", irq, 0);
        irq_en = 1'b1;
        pulse_read();
        chk("R9 read clears NT", irq_status, 0);

        // realign mid multiframe
        te_mode = 1'b1; irq_every_nibble = 1'b0; rd_f = 0; host_tx_reg = 8'h5A;
        for (int f = 1; f <= 7; f++) send_frame(0, 5'h0A, f);
        send_mf(1, 20'hDEAD5);
        chk("R2 realigned rx", rx_nibbles, 20'hDEAD5);
        chk("R2 realigned tx", tx_q_nibble, 4'h5);
        chk("R7 realigned status", irq_status, 1);

        finish_up();
    end
endmodule